// File: doc/BRIEF.md
# Password Access Controller with Tamper Counter

This block sits between the command decoder of a serial memory and its storage array. Every array access passes through it, and it decides whether the access may proceed. The block holds three 64-bit secrets: one for reading the protected region, one for writing the protected region, and one for writing the two small one-time-programmable blocks. The decoder presents a 64-bit candidate together with a kind selector. A match opens the matching unlock flag for the rest of the session. A mismatch closes all flags and increments a bad-entry count.

A 3-bit size code sets how much of the main array, counted upward from address 0, is protected. Bytes above that limit need no password. The size code and a lock-enable bit form the configuration. This configuration can no longer be changed while the write-protect pin is high and the lock-enable bit is set. The eighth bad entry since power-on sets a tamper bit for good, and that bit appears in the 32-bit device ID word. A refused read returns all-ones data and never strobes the array. A refused write is dropped and reported by a one-cycle error pulse.

Top module: `pwd_access_ctrl`

## Requirements
- R1: The size code maps to a protected byte count starting at address 0: code 0 = 64, 1 = 128, 2 = 256, 3 = 512, 4 = 2048, 5 = 4096, 6 = the whole 8192-byte array, 7 = nothing.
- R2: A main-array access at an address at or above the protected byte count is granted with no password.
- R3: A protected read without the read flag keeps `arr_rd_en` low and returns 8'hFF. With the flag set, it raises `arr_rd_en` and returns `arr_rdata`.
- R4: A protected write without the write flag keeps `arr_wr_en` low, and `err_pulse` is high for exactly the one cycle after it. With the flag set, the write is passed to the array.
- R5: A write to the one-time-programmable space (`acc_otp`=1) needs the OTP flag. Reads of that space are always granted.
- R6: The kind codes are 0 = read, 1 = write, 2 = OTP, and 3 never matches. A compare (`pw_valid`=1, `pw_set`=0) that matches the stored value of its kind sets that flag from the next cycle on. Any other compare clears all three flags and counts as a bad entry.
- R7: The eighth bad entry since reset sets `dev_id[31]`, counting every bad entry whether or not good entries came between them. The bit then stays set until reset, and the count saturates at 8.
- R8: While `wp`=1 and the stored lock-enable bit is 1, configuration writes (size and lock-enable) are ignored. In every other state they take effect on the next cycle.
- R9: After reset, all three stored secrets are zero, all flags are clear, the size code is 7, and `dev_id` equals 32'h1A5C0003 with bit 31 clear.
- R10: A load (`pw_valid`=1, `pw_set`=1) replaces the stored secret of its kind only while that kind's flag is set. Otherwise it is ignored and is not counted as a bad entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| pw_valid | input | 1 | Secret operation strobe |
| pw_set | input | 1 | 0 = compare, 1 = load new secret |
| pw_kind | input | 2 | Secret selector (0 read, 1 write, 2 OTP) |
| pw_value | input | 64 | Candidate or new secret |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_size | input | 3 | New protected size code |
| cfg_lock | input | 1 | New lock-enable bit |
| wp | input | 1 | Write-protect pin |
| acc_valid | input | 1 | Array access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_otp | input | 1 | Access targets the OTP blocks |
| acc_addr | input | 13 | Byte address |
| arr_rdata | input | 8 | Read data from the array |
| arr_rd_en | output | 1 | Granted read strobe to the array |
| arr_wr_en | output | 1 | Granted write strobe to the array |
| rd_data | output | 8 | Read data to the decoder (8'hFF when refused) |
| err_pulse | output | 1 | One-cycle pulse after a refused write |
| dev_id | output | 32 | Device ID word with the tamper bit at 31 |

## Verification
The assertions assume one secret operation per cycle, with `pw_kind` and `pw_value` held steady for the cycle `pw_valid` is high. They also assume that access requests are single-cycle strobes whose result the decoder acts on in the same cycle. The bench drives every strobe for exactly one cycle from the falling edge and releases it before the next. It never overlaps a secret operation with a configuration write, so each flag, count and configuration change can be attributed to one stimulus.

// File: rtl/pac_pkg.sv
// Package: shared types and constants for the password access controller.
// Assumes: three secret kinds with a fixed encoding used at the top ports.
package pac_pkg;
    localparam int NUM_KINDS = 3;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_OTP   = 2'd2,
        KIND_NONE  = 2'd3
    } kind_e;

    localparam logic [2:0] SIZE_CODE_RESET = 3'd7;
endpackage

// File: rtl/pac_secret_bank.sv
// Secret bank: stores one secret per kind, compares candidates and keeps the
// session unlock flags. Assumes one operation per cycle on the pw_* inputs.
// A load of a kind is accepted only while that kind is unlocked.
module pac_secret_bank #(
    parameter int PW_W  = 64,
    parameter int KINDS = pac_pkg::NUM_KINDS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pw_valid,
    input  logic             pw_set,
    input  logic [1:0]       pw_kind,
    input  logic [PW_W-1:0]  pw_value,
    output logic [KINDS-1:0] unlock,
    output logic             bad_entry
);
    logic [KINDS-1:0] match_vec;
    logic [KINDS-1:0] unlock_q;
    logic             compare;

    assign compare = pw_valid && !pw_set;

    for (genvar k = 0; k < KINDS; k++) begin : g_slot
        logic [PW_W-1:0] slot_q;
        logic            sel;

        assign sel          = (pw_kind == 2'(k));
        assign match_vec[k] = sel && (pw_value == slot_q);

        // Replace the stored secret when a load targets an unlocked slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= '0;
            else if (pw_valid && pw_set && sel && unlock_q[k])
                slot_q <= pw_value;
        end

        // R10
        locked_load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pw_valid && pw_set && sel && !unlock_q[k]) |=> $stable(slot_q));
    end

    // Open the matching flag on a good compare, close all on a bad one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            unlock_q <= '0;
        else if (compare)
            unlock_q <= (|match_vec) ? (unlock_q | match_vec) : '0;
    end

    assign bad_entry = compare && !(|match_vec);
    assign unlock    = unlock_q;

    // R6
    bad_closes_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_entry |=> (unlock == '0));

    // R6
    flags_only_open_on_compare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !compare |=> $stable(unlock));
endmodule

// File: rtl/pac_tamper.sv
// Tamper counter: counts bad secret entries since power-on, saturating at the
// limit, and latches the tamper bit when the limit is reached. Good entries
// never touch the count. Assumes bad_entry is a one-cycle strobe.
module pac_tamper #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bad_entry,
    output logic tamper
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;
    logic             tamper_q;

    // Count bad entries up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (bad_entry && cnt_q != LIM_V)
            cnt_q <= cnt_q + 1'b1;
    end

    // Latch tamper on the entry that brings the count to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tamper_q <= 1'b0;
        else if (bad_entry && cnt_q == LIM_V - 1'b1)
            tamper_q <= 1'b1;
    end

    assign tamper = tamper_q;

    // R7
    count_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM_V);

    // R7
    tamper_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tamper_q |=> tamper_q);

    // R7
    tamper_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tamper_q == (cnt_q == LIM_V));
endmodule

// File: rtl/pac_region.sv
// Region decoder: holds the size code and lock-enable bit, applies the
// write-protect lock, and flags addresses inside the protected span that
// starts at address 0. Assumes ADDR_W >= 13 so every table entry fits.
module pac_region #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_size,
    input  logic              cfg_lock,
    input  logic              wp,
    input  logic [ADDR_W-1:0] addr,
    output logic              in_region
);
    localparam int LIM_W = ADDR_W + 1;

    logic [2:0]       size_q;
    logic             lock_q;
    logic             frozen;
    logic [LIM_W-1:0] limit;

    assign frozen = wp && lock_q;

    // Accept configuration writes unless frozen by pin and lock bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= pac_pkg::SIZE_CODE_RESET;
            lock_q <= 1'b0;
        end else if (cfg_wr && !frozen) begin
            size_q <= cfg_size;
            lock_q <= cfg_lock;
        end
    end

    // Translate the size code into a byte limit.
    always_comb begin
        case (size_q)
            3'd0:    limit = LIM_W'(64);
            3'd1:    limit = LIM_W'(128);
            3'd2:    limit = LIM_W'(256);
            3'd3:    limit = LIM_W'(512);
            3'd4:    limit = LIM_W'(2048);
            3'd5:    limit = LIM_W'(4096);
            3'd6:    limit = LIM_W'(1) << ADDR_W;
            default: limit = '0;
        endcase
    end

    assign in_region = ({1'b0, addr} < limit);

    // R8
    frozen_cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> ($stable(size_q) && $stable(lock_q)));
endmodule

// File: rtl/pwd_access_ctrl.sv
// Password access controller top: combines the secret bank, tamper counter
// and region decoder, and grants or refuses each array access in the cycle
// it is presented. Assumes the array read data is valid in the same cycle.
module pwd_access_ctrl #(
    parameter int          PW_W       = 64,
    parameter int          ADDR_W     = 13,
    parameter int          DATA_W     = 8,
    parameter int          TAMPER_LIM = 8,
    parameter int          TAMPER_BIT = 31,
    parameter logic [31:0] ID_BASE    = 32'h1A5C_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pw_valid,
    input  logic              pw_set,
    input  logic [1:0]        pw_kind,
    input  logic [PW_W-1:0]   pw_value,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_size,
    input  logic              cfg_lock,
    input  logic              wp,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_otp,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              arr_rd_en,
    output logic              arr_wr_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_pulse,
    output logic [31:0]       dev_id
);
    import pac_pkg::*;

    logic [NUM_KINDS-1:0] unlock;
    logic                 bad_entry;
    logic                 tamper;
    logic                 in_region;
    logic                 read_ok;
    logic                 write_ok;
    logic                 err_q;

    pac_secret_bank #(.PW_W(PW_W), .KINDS(NUM_KINDS)) u_bank (
        .clk(clk), .rst_n(rst_n), .pw_valid(pw_valid), .pw_set(pw_set),
        .pw_kind(pw_kind), .pw_value(pw_value),
        .unlock(unlock), .bad_entry(bad_entry)
    );

    pac_tamper #(.LIMIT(TAMPER_LIM)) u_tamper (
        .clk(clk), .rst_n(rst_n), .bad_entry(bad_entry), .tamper(tamper)
    );

    pac_region #(.ADDR_W(ADDR_W)) u_region (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_size(cfg_size),
        .cfg_lock(cfg_lock), .wp(wp), .addr(acc_addr), .in_region(in_region)
    );

    // Decide permission from target space, region and session flags.
    always_comb begin
        if (acc_otp) begin
            read_ok  = 1'b1;
            write_ok = unlock[KIND_OTP];
        end else begin
            read_ok  = !in_region || unlock[KIND_READ];
            write_ok = !in_region || unlock[KIND_WRITE];
        end
    end

    assign arr_rd_en = acc_valid && !acc_write && read_ok;
    assign arr_wr_en = acc_valid && acc_write && write_ok;
    assign rd_data   = arr_rd_en ? arr_rdata : '1;

    // Flag a refused write for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= acc_valid && acc_write && !write_ok;
    end

    assign err_pulse = err_q;

    // Insert the tamper bit into the ID word.
    always_comb begin
        dev_id             = ID_BASE;
        dev_id[TAMPER_BIT] = tamper;
    end

    // R4
    refused_write_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !arr_wr_en) |=> err_pulse);

    // R4
    protected_write_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_en && !acc_otp && in_region) |-> unlock[KIND_WRITE]);

    // R3
    refused_read_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && !arr_rd_en) |-> (rd_data == '1));

    // R5
    otp_write_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_en && acc_otp) |-> unlock[KIND_OTP]);

    // R7
    id_tamper_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_id[TAMPER_BIT] |=> dev_id[TAMPER_BIT]);
endmodule

// File: tb/pwd_access_ctrl_test.sv
module pwd_access_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ID = 32'h1A5C_0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pw_valid = 1'b0, pw_set = 1'b0;
    logic [1:0]  pw_kind = 2'd0;
    logic [63:0] pw_value = '0;
    logic        cfg_wr = 1'b0, cfg_lock = 1'b0, wp = 1'b0;
    logic [2:0]  cfg_size = 3'd0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_otp = 1'b0;
    logic [12:0] acc_addr = '0;
    logic [7:0]  arr_rdata;
    logic        arr_rd_en, arr_wr_en, err_pulse;
    logic [7:0]  rd_data;
    logic [31:0] dev_id;

    int checks = 0;
    int errors = 0;
    int bad_n  = 0;

    assign arr_rdata = acc_addr[7:0] ^ 8'h3C;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwd_access_ctrl uut (
        .clk(clk), .rst_n(rst_n), .pw_valid(pw_valid), .pw_set(pw_set),
        .pw_kind(pw_kind), .pw_value(pw_value), .cfg_wr(cfg_wr),
        .cfg_size(cfg_size), .cfg_lock(cfg_lock), .wp(wp),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_otp(acc_otp),
        .acc_addr(acc_addr), .arr_rdata(arr_rdata), .arr_rd_en(arr_rd_en),
        .arr_wr_en(arr_wr_en), .rd_data(rd_data), .err_pulse(err_pulse),
        .dev_id(dev_id)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int limit_of(input int code);
        case (code)
            0: return 64;   1: return 128;  2: return 256;  3: return 512;
            4: return 2048; 5: return 4096; 6: return 8192; default: return 0;
        endcase
    endfunction

    // Compare or load a secret for one cycle.
    task automatic secret(input logic set, input logic [1:0] kind, input logic [63:0] v,
                          input bit expect_bad);
        @(negedge clk);
        pw_valid = 1'b1; pw_set = set; pw_kind = kind; pw_value = v;
        @(negedge clk);
        pw_valid = 1'b0; pw_set = 1'b0;
        if (expect_bad) bad_n++;
    endtask

    task automatic config_write(input logic [2:0] size, input logic lock);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_size = size; cfg_lock = lock;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Read one byte; check grant and returned data.
    task automatic read_chk(input string req, input logic otp, input int addr, input bit granted);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_otp = otp; acc_addr = 13'(addr);
        #1;
        chk(req, arr_rd_en, granted);
        chk(req, rd_data, granted ? (8'(addr) ^ 8'h3C) : 8'hFF);
        @(negedge clk);
        acc_valid = 1'b0; acc_otp = 1'b0;
    endtask

    // Write one byte; check grant and the error pulse in the next cycle only.
    task automatic write_chk(input string req, input logic otp, input int addr, input bit granted);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_otp = otp; acc_addr = 13'(addr);
        #1;
        chk(req, arr_wr_en, granted);
        @(posedge clk); #1;
        acc_valid = 1'b0; acc_write = 1'b0; acc_otp = 1'b0;
        chk(req, err_pulse, !granted);
        @(posedge clk); #1;
        chk(req, err_pulse, 1'b0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R9 id", dev_id, ID);
        read_chk("R9 size none", 1'b0, 0, 1'b1);
        write_chk("R9 no flags", 1'b1, 1, 1'b0);
    endtask

    task automatic t_region;
        for (int c = 0; c < 8; c++) begin
            int lim;
            lim = limit_of(c);
            config_write(3'(c), 1'b0);
            if (lim > 0) read_chk("R1 inside", 1'b0, lim - 1, 1'b0);
            if (lim < 8192) read_chk("R2 outside", 1'b0, lim, 1'b1);
            if (lim > 0 && lim < 8192) write_chk("R2 write outside", 1'b0, lim, 1'b1);
        end
    endtask

    task automatic t_read_unlock;
        config_write(3'd0, 1'b0);
        read_chk("R3 locked", 1'b0, 10, 1'b0);
        secret(1'b0, 2'd0, 64'd0, 1'b0);
        read_chk("R3 R6 unlocked", 1'b0, 10, 1'b1);
        write_chk("R6 other kind closed", 1'b0, 10, 1'b0);
    endtask

    task automatic t_write_unlock;
        write_chk("R4 refused", 1'b0, 5, 1'b0);
        secret(1'b0, 2'd1, 64'd0, 1'b0);
        write_chk("R4 granted", 1'b0, 5, 1'b1);
    endtask

    task automatic t_load;
        secret(1'b1, 2'd1, 64'hDEAD_BEEF_0123_4567, 1'b0);
        secret(1'b0, 2'd1, 64'd0, 1'b1);
        write_chk("R6 R10 old value now wrong", 1'b0, 5, 1'b0);
        read_chk("R6 all flags closed", 1'b0, 5, 1'b0);
        secret(1'b0, 2'd1, 64'hDEAD_BEEF_0123_4567, 1'b0);
        write_chk("R10 new value opens", 1'b0, 5, 1'b1);
        secret(1'b1, 2'd0, 64'h1111_2222_3333_4444, 1'b0);
        secret(1'b0, 2'd0, 64'd0, 1'b0);
        read_chk("R10 locked load ignored", 1'b0, 5, 1'b1);
    endtask

    task automatic t_otp;
        write_chk("R5 otp refused", 1'b1, 3, 1'b0);
        read_chk("R5 otp read free", 1'b1, 3, 1'b1);
        secret(1'b0, 2'd2, 64'd0, 1'b0);
        write_chk("R5 otp granted", 1'b1, 3, 1'b1);
    endtask

    task automatic t_lock;
        config_write(3'd2, 1'b1);
        secret(1'b0, 2'd3, 64'd0, 1'b1);
        read_chk("R8 size 2 inside", 1'b0, 255, 1'b0);
        read_chk("R8 size 2 outside", 1'b0, 256, 1'b1);
        wp = 1'b1;
        config_write(3'd7, 1'b0);
        read_chk("R8 frozen", 1'b0, 255, 1'b0);
        wp = 1'b0;
        config_write(3'd7, 1'b0);
        read_chk("R8 released", 1'b0, 255, 1'b1);
    endtask

    task automatic t_tamper;
        while (bad_n < 7) begin
            secret(1'b0, 2'd3, 64'd5, 1'b1);
            secret(1'b0, 2'd0, 64'd0, 1'b0);
        end
        #1;
        chk("R7 seven bad", dev_id[31], 1'b0);
        secret(1'b0, 2'd2, 64'd9, 1'b1);
        #1;
        chk("R7 eighth bad", dev_id, ID | 32'h8000_0000);
        secret(1'b0, 2'd0, 64'd0, 1'b0);
        secret(1'b0, 2'd3, 64'd0, 1'b1);
        #1;
        chk("R7 sticky", dev_id[31], 1'b1);
    endtask

    initial begin
        t_reset();
        t_region();
        t_read_unlock();
        t_write_unlock();
        t_load();
        t_otp();
        t_lock();
        t_tamper();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule